// File: doc/BRIEF.md
# OTP Row Command-Sequenced Reader

This block sits on the microcontroller bus in front of a memory device's EEPROM read path. It watches bus write cycles for a fixed three-write unlock sequence. When the sequence completes, the block enters OTP-row read mode. In that mode, a bus read made while any EEPROM sector select is high returns a byte from a 64-byte one-time-programmable row instead of from the main array. A single return write leaves the mode, and normal array reads resume.

The OTP row is held in an internal byte memory written through a dedicated load port. That port stands in for the device's programming path, and a testbench uses it to fill the row. Outside OTP mode, and for reads with no sector select, the read data of the main array passes straight through. Every bus read yields exactly one registered result two cycles after its strobe. The mode flag is exported so that entry and exit can be observed.

Top module: `otp_row_reader`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `otp_mode` is 0, `rd_valid` is 0 and `rd_data` is 0x00.
- R2: Three consecutive bus writes enter OTP mode, and `otp_mode` reads 1 from the clock edge that accepts the third write. The writes are address 0x555 with data 0xAA, then 0x2AA with 0x55, then 0x555 with 0x90, and all 12 address bits are compared.
- R3: Outside OTP mode, a write that does not match the step the sequencer expects sends the sequencer back to its start. The sequence must then be restarted from its first write.
- R4: A write of data 0xF0 to any address clears `otp_mode` and restarts the sequencer, whatever the current state. It is visible from the edge that accepts it.
- R5: In OTP mode, a read with at least one `sect_sel` bit high and address bit 6 at 0 returns the row byte selected by address bits 5..0.
- R6: In OTP mode, a read with a sector select high and address bit 6 at 1 returns 0xFF and leaves `otp_mode` at 1.
- R7: In OTP mode, a read with all `sect_sel` bits low returns `arr_rdata` as sampled with the read strobe.
- R8: Outside OTP mode, every read returns `arr_rdata` as sampled with the read strobe, unchanged.
- R9: In OTP mode, bus writes with data other than 0xF0 are ignored: the mode stays set and the row contents are unchanged.
- R10: Each cycle with `bus_rd` high produces exactly one cycle of `rd_valid` two clock edges later, with `rd_data` valid in that cycle. Back-to-back reads are allowed.
- R11: A write on the load port (`ld_en`, `ld_addr`, `ld_data`) updates the row byte. A later OTP read returns the new value, and the load can be made in or out of OTP mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe, one cycle per write |
| bus_rd | input | 1 | Bus read strobe, one cycle per read |
| bus_addr | input | ADDR_W (12) | Low bus address bits |
| bus_wdata | input | 8 | Bus write data |
| sect_sel | input | NSECT (8) | EEPROM sector selects, active high |
| arr_rdata | input | 8 | Read data from the main EEPROM array |
| ld_en | input | 1 | Row load strobe |
| ld_addr | input | 6 | Row load byte index |
| ld_data | input | 8 | Row load data |
| rd_data | output | 8 | Registered read result |
| rd_valid | output | 1 | Read result valid |
| otp_mode | output | 1 | OTP-row read mode active |

## Verification
A sequencer stuck in a wrong step shows up on `otp_mode` at the edge after the write that should have moved it. It also shows up two cycles later on `rd_data`, when a following sector-selected read returns array data instead of a row byte, or the reverse. A wrong source choice or a stale row entry appears on the result of the very read that caused it. A lost or doubled pipeline stage shows as a `rd_valid` pulse with no pending expectation, or as expectations left over at the end of the run.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_STEP1 = 2'd1,
    SQ_STEP2 = 2'd2,
    SQ_OTP   = 2'd3
  } seq_st_t;

  typedef enum logic [1:0] {
    SRC_ARRAY = 2'd0,
    SRC_ROW   = 2'd1,
    SRC_BLANK = 2'd2
  } src_t;

  localparam int unsigned CMD_AW = 12;
  localparam logic [CMD_AW-1:0] UNLK_ADDR_A = 12'h555;
  localparam logic [CMD_AW-1:0] UNLK_ADDR_B = 12'h2AA;
  localparam logic [7:0] UNLK_DATA_1 = 8'hAA;
  localparam logic [7:0] UNLK_DATA_2 = 8'h55;
  localparam logic [7:0] UNLK_DATA_3 = 8'h90;
  localparam logic [7:0] RETURN_DATA = 8'hF0;
  localparam logic [7:0] BLANK_BYTE  = 8'hFF;
endpackage

// File: rtl/otp_cmd_seq.sv
module otp_cmd_seq
  import otp_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic              mode
);
  seq_st_t st_q;

  logic hit_a1, hit_b2, hit_a3, is_ret;

  always_comb begin
    is_ret = (wr_data == DW'(RETURN_DATA));
    hit_a1 = (wr_addr == ADDR_W'(UNLK_ADDR_A)) && (wr_data == DW'(UNLK_DATA_1));
    hit_b2 = (wr_addr == ADDR_W'(UNLK_ADDR_B)) && (wr_data == DW'(UNLK_DATA_2));
    hit_a3 = (wr_addr == ADDR_W'(UNLK_ADDR_A)) && (wr_data == DW'(UNLK_DATA_3));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= SQ_IDLE;
    end else if (wr_en) begin
      if (is_ret) begin
        st_q <= SQ_IDLE;
      end else begin
        unique case (st_q)
          SQ_IDLE:  st_q <= hit_a1 ? SQ_STEP1 : SQ_IDLE;
          SQ_STEP1: st_q <= hit_b2 ? SQ_STEP2 : SQ_IDLE;
          SQ_STEP2: st_q <= hit_a3 ? SQ_OTP   : SQ_IDLE;
          SQ_OTP:   st_q <= SQ_OTP;
          default:  st_q <= SQ_IDLE;
        endcase
      end
    end
  end

  assign mode = (st_q == SQ_OTP);
endmodule

// File: rtl/otp_row_store.sv
module otp_row_store #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/otp_read_path.sv
module otp_read_path
  import otp_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  src_t          src,
  input  logic [DW-1:0] arr_rdata,
  input  logic [DW-1:0] row_q,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic          v1_q;
  src_t          src1_q;
  logic [DW-1:0] arr1_q;
  logic [DW-1:0] sel_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q   <= 1'b0;
      src1_q <= SRC_ARRAY;
      arr1_q <= '0;
    end else begin
      v1_q <= rd_en;
      if (rd_en) begin
        src1_q <= src;
        arr1_q <= arr_rdata;
      end
    end
  end

  always_comb begin
    unique case (src1_q)
      SRC_ROW:   sel_d = row_q;
      SRC_BLANK: sel_d = DW'(BLANK_BYTE);
      default:   sel_d = arr1_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= v1_q;
      if (v1_q) rd_data <= sel_d;
    end
  end
endmodule

// File: rtl/otp_row_reader.sv
module otp_row_reader
  import otp_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NSECT  = 8,
  parameter int unsigned DW     = 8,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned RAW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic [NSECT-1:0]  sect_sel,
  input  logic [DW-1:0]     arr_rdata,
  input  logic              ld_en,
  input  logic [RAW-1:0]    ld_addr,
  input  logic [DW-1:0]     ld_data,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid,
  output logic              otp_mode
);
  logic [DW-1:0] row_q;
  src_t          src_d;
  logic          any_sect;

  otp_cmd_seq #(.ADDR_W(ADDR_W), .DW(DW)) seq_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_wr),
    .wr_addr (bus_addr),
    .wr_data (bus_wdata),
    .mode    (otp_mode)
  );

  otp_row_store #(.DEPTH(DEPTH), .DW(DW)) row_i (
    .clk     (clk),
    .ld_en   (ld_en),
    .ld_addr (ld_addr),
    .ld_data (ld_data),
    .rd_en   (bus_rd),
    .rd_addr (bus_addr[RAW-1:0]),
    .rd_q    (row_q)
  );

  always_comb begin
    any_sect = |sect_sel;
    if (!otp_mode || !any_sect) src_d = SRC_ARRAY;
    else if (bus_addr[RAW])     src_d = SRC_BLANK;
    else                        src_d = SRC_ROW;
  end

  otp_read_path #(.DW(DW)) rp_i (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (bus_rd),
    .src       (src_d),
    .arr_rdata (arr_rdata),
    .row_q     (row_q),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );
endmodule

// File: rtl/otp_row_reader_chk.sv
module otp_row_reader_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NSECT  = 8,
  parameter int unsigned DW     = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [NSECT-1:0]  sect_sel,
  input logic [DW-1:0]     arr_rdata,
  input logic [DW-1:0]     rd_data,
  input logic              rd_valid,
  input logic              otp_mode
);
  // R2
  mode_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(otp_mode) |-> $past(bus_wr && bus_wdata == DW'(8'h90) && bus_addr == ADDR_W'(12'h555)));

  // R4
  return_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_wdata == DW'(8'hF0)) |=> !otp_mode);

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (otp_mode && !(bus_wr && bus_wdata == DW'(8'hF0))) |=> otp_mode);

  // R10
  valid_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> ##1 rd_valid);

  // R10
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> ##1 !rd_valid);

  // R6
  blank_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && otp_mode && (|sect_sel) && bus_addr[6]) |=> ##1 (rd_data == DW'(8'hFF)));

  // R8
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !otp_mode) |=> ##1 (rd_data == $past(arr_rdata, 2)));
endmodule

bind otp_row_reader otp_row_reader_chk #(.ADDR_W(ADDR_W), .NSECT(NSECT), .DW(DW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .sect_sel  (sect_sel),
  .arr_rdata (arr_rdata),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .otp_mode  (otp_mode)
);

// File: tb/otp_row_reader_tb_top.sv
module otp_row_reader_tb_top;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned NSECT  = 8;
  localparam int unsigned DEPTH  = 64;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0]        bus_wdata = '0;
  logic [NSECT-1:0]  sect_sel = '0;
  logic [7:0]        arr_rdata = '0;
  logic              ld_en = 1'b0;
  logic [5:0]        ld_addr = '0;
  logic [7:0]        ld_data = '0;
  logic [7:0]        rd_data;
  logic              rd_valid;
  logic              otp_mode;

  always #2 clk = ~clk;

  otp_row_reader #(.ADDR_W(ADDR_W), .NSECT(NSECT), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .sect_sel(sect_sel), .arr_rdata(arr_rdata),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .otp_mode(otp_mode)
  );

  typedef struct {
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t      sb_q[$];
  logic [7:0] row_model [DEPTH];
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done  = 1'b0;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [7:0] sel,
                          input logic [7:0] arr, input logic [7:0] exp, input string req);
    item_t it;
    bus_rd = 1'b1; bus_addr = a; sect_sel = sel; arr_rdata = arr;
    it.exp = exp; it.req = req;
    sb_q.push_back(it);
    @(posedge clk); #1;
    bus_rd = 1'b0; sect_sel = '0; arr_rdata = 8'h00;
  endtask

  task automatic load_row(input logic [5:0] a, input logic [7:0] d);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    row_model[a] = d;
    @(posedge clk); #1;
    ld_en = 1'b0;
  endtask

  task automatic unlock();
    bus_write(12'h555, 8'hAA);
    bus_write(12'h2AA, 8'h55);
    bus_write(12'h555, 8'h90);
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (sb_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R10: actual rd_valid=1 expected no pending read");
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(it.req, rd_data, it.exp);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    check("R1 mode in reset", {7'd0, otp_mode}, 8'h00);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R1 mode", {7'd0, otp_mode}, 8'h00);
    check("R1 valid", {7'd0, rd_valid}, 8'h00);
    check("R1 data", rd_data, 8'h00);

    for (int i = 0; i < DEPTH; i++) load_row(6'(i), 8'((i * 37 + 11) ^ 8'h5A));

    // R8 pass-through outside mode, with and without selects
    bus_read(12'h012, 8'h01, 8'h3C, 8'h3C, "R8");
    bus_read(12'h045, 8'h80, 8'hA7, 8'hA7, "R8");
    bus_read(12'h003, 8'h00, 8'h5E, 8'h5E, "R8");

    // R3 mismatches restart the sequence
    bus_write(12'h555, 8'hAA);
    bus_write(12'h2AA, 8'h00);
    bus_write(12'h2AA, 8'h55);
    bus_write(12'h555, 8'h90);
    check("R3 bad step2 data", {7'd0, otp_mode}, 8'h00);
    bus_write(12'h555, 8'hAA);
    bus_write(12'h2AA, 8'h55);
    bus_write(12'h554, 8'h90);
    check("R3 bad step3 addr", {7'd0, otp_mode}, 8'h00);
    bus_read(12'h005, 8'h02, 8'h61, 8'h61, "R3 still array");

    // R4 return mid-sequence
    bus_write(12'h555, 8'hAA);
    bus_write(12'h7FF, 8'hF0);
    bus_write(12'h2AA, 8'h55);
    bus_write(12'h555, 8'h90);
    check("R4 return mid-seq", {7'd0, otp_mode}, 8'h00);

    // R2 entry timing
    bus_write(12'h555, 8'hAA);
    check("R2 after write1", {7'd0, otp_mode}, 8'h00);
    bus_write(12'h2AA, 8'h55);
    check("R2 after write2", {7'd0, otp_mode}, 8'h00);
    bus_write(12'h555, 8'h90);
    check("R2 after write3", {7'd0, otp_mode}, 8'h01);

    // R5 whole row, back-to-back, rotating selects (R10)
    for (int i = 0; i < DEPTH; i++)
      bus_read(12'(i) | 12'h080, 8'(1 << (i % NSECT)), 8'h11, row_model[i], "R5");

    // R6 A6 set
    bus_read(12'h040, 8'h04, 8'h22, 8'hFF, "R6");
    bus_read(12'h07F, 8'hFF, 8'h33, 8'hFF, "R6");
    check("R6 mode kept", {7'd0, otp_mode}, 8'h01);

    // R7 no sector select
    bus_read(12'h00A, 8'h00, 8'h9D, 8'h9D, "R7");

    // R9 other writes ignored
    bus_write(12'h00A, 8'h00);
    bus_write(12'h555, 8'hAA);
    check("R9 mode kept", {7'd0, otp_mode}, 8'h01);
    bus_read(12'h00A, 8'h10, 8'h44, row_model[10], "R9 row intact");

    // R11 reload in mode
    load_row(6'd10, 8'hC3);
    bus_read(12'h00A, 8'h20, 8'h44, 8'hC3, "R11");

    // R4 exit from mode at arbitrary address
    bus_write(12'h123, 8'hF0);
    check("R4 exit", {7'd0, otp_mode}, 8'h00);
    bus_read(12'h00A, 8'h20, 8'h6B, 8'h6B, "R4 array after exit");

    // re-entry works after exit
    unlock();
    check("R2 re-entry", {7'd0, otp_mode}, 8'h01);
    bus_read(12'h03F, 8'h40, 8'h00, row_model[63], "R5 last byte");
    bus_write(12'h000, 8'hF0);

    repeat (6) @(posedge clk);
    #1;
    check("R10 all reads answered", 8'(sb_q.size()), 8'h00);
    finish_run();
  end
endmodule